// File: doc/BRIEF.md
# Indexed Doorbell Address Decoder

This block watches byte-addressed write transactions that land in one window of a memory-mapped region. It decides which device notification ("doorbell") a driver has rung. Each doorbell has its own address: a fixed base offset plus the doorbell index times a per-device stride. The stride is a power of two, so the index comes from a subtract and a right shift.

A stride of zero selects a shared-address mode. In that mode every doorbell sits at the base offset, and the written value carries the index. The access width is a build-time parameter of 1, 2 or 4 bytes. Each write is checked against that width's byte-lane pattern and alignment.

For each accepted write the block produces one result a cycle later:
- a single-cycle ring pulse carrying the index, or
- a single-cycle error strobe, when the write was misaligned, out of range or had the wrong byte lanes.

Writes that fall outside the window are not this block's business and produce nothing.

Top module: `dbell_decoder`

## Requirements
- R1: After reset, and until the first write is accepted, `ring_pulse`, `ring_err` and `ring_idx` are all 0.
- R2: With a non-zero stride S, a write to BASE_OFF + i*S with i <= MAX_IDX and correct byte enables gives `ring_pulse`=1 with `ring_idx`=i in the cycle after the write's clock edge, and only in that cycle.
- R3: Valid writes on consecutive cycles give pulses on consecutive cycles, each with its own index, in the order written.
- R4: Some writes inside the window raise `ring_err` for one cycle, with no pulse, in the cycle after the write. This happens when the offset from BASE_OFF is not a whole multiple of S (non-zero S). It also happens when the address is not a multiple of the access width.
- R5: A write inside the window whose index exceeds MAX_IDX raises `ring_err` with no pulse. For non-zero S the index is offset/S. For zero S it is the written value.
- R6: Each write is checked against an expected byte-enable pattern. That pattern is WIDTH_B consecutive ones starting at bit addr mod BUS_BYTES (bit 0 is the lowest byte lane). Any other pattern, including one that would run past the top lane, raises `ring_err` with no pulse.
- R7: A write whose address lies below BASE_OFF or at or above BASE_OFF + WIN_LEN produces neither a pulse nor an error.
- R8: A cycle with `wr_valid` low produces neither a pulse nor an error in the following cycle.
- R9: With S = 0, only the base address is a doorbell, and any other in-window offset is an error. The index is the WIDTH_B-byte value in the lanes starting at addr mod BUS_BYTES, read little-endian. The other lanes of `wr_data` are ignored.
- R10: `ring_pulse` and `ring_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_addr | input | ADDR_W | Byte address of the write within the region |
| wr_be | input | BUS_BYTES | Byte enables, bit 0 = lowest byte lane |
| wr_data | input | 8*BUS_BYTES | Write data, lane n in bits 8n+7:8n |
| ring_pulse | output | 1 | One-cycle doorbell strobe |
| ring_idx | output | IDX_W | Index of the doorbell rung, valid with `ring_pulse` |
| ring_err | output | 1 | One-cycle strobe for a rejected in-window write |

## Verification
Every result belongs to the write presented before one rising edge. It shows up on `ring_pulse`, `ring_idx` or `ring_err` right after that edge, and lasts exactly one cycle, because a single register stage sits between the inputs and the outputs. The driver applies each write at a falling edge and queues the outcome it expects, stamped with the current cycle count. The monitor samples at the next falling edge and compares only queue entries stamped in an earlier cycle, so each comparison lands precisely one edge after its stimulus. Idle cycles also queue a "nothing" outcome, so stray pulses are caught. Two instances share the stimulus: one uses a shifted stride with 4-byte access, the other uses the shared address with 2-byte access in an upper lane.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  // Result class of one observed write.
  typedef enum logic [1:0] {
    DB_NONE  = 2'd0,
    DB_RING  = 2'd1,
    DB_FAULT = 2'd2
  } db_kind_e;

  // Diagnosis of a write against the window rules.
  typedef struct packed {
    logic in_win;
    logic width_bad;
    logic lanes_bad;
    logic stride_bad;
    logic range_bad;
  } db_diag_t;

  function automatic int unsigned idx_bits(input int unsigned max_idx);
    return (max_idx < 1) ? 1 : $clog2(max_idx + 1);
  endfunction

  function automatic int unsigned stride_shift(input int unsigned stride);
    return (stride < 2) ? 0 : $clog2(stride);
  endfunction

endpackage

// File: rtl/dbell_window.sv
module dbell_window #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned WIDTH_B   = 4,
  parameter int unsigned BASE_OFF  = 256,
  parameter int unsigned WIN_LEN   = 64,
  localparam int unsigned LANE_W   = (BUS_BYTES < 2) ? 1 : $clog2(BUS_BYTES)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_BYTES-1:0] be,
  output logic [ADDR_W-1:0]    off,
  output logic [LANE_W-1:0]    lane,
  output logic                 in_win,
  output logic                 width_bad,
  output logic                 lanes_bad
);

  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] LEN_A   = ADDR_W'(WIN_LEN);
  localparam logic [ADDR_W-1:0] WALIGN  = ADDR_W'(WIDTH_B - 1);
  localparam int unsigned       WIDE_W  = 2 * BUS_BYTES;
  localparam logic [WIDE_W-1:0] WMASK   = WIDE_W'((1 << WIDTH_B) - 1);

  logic [WIDE_W-1:0] lane_pattern;

  always_comb begin
    off          = addr - BASE_A;
    lane         = addr[LANE_W-1:0];
    in_win       = (addr >= BASE_A) && (off < LEN_A);
    width_bad    = (addr & WALIGN) != '0;
    lane_pattern = WMASK << lane;
    // Pattern spilling past the top lane can never be met.
    lanes_bad    = (be != lane_pattern[BUS_BYTES-1:0]) ||
                   (lane_pattern[WIDE_W-1:BUS_BYTES] != '0);
  end

endmodule

// File: rtl/dbell_index.sv
module dbell_index #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned WIDTH_B   = 4,
  parameter int unsigned STRIDE    = 8,
  parameter int unsigned MAX_IDX   = 5,
  localparam int unsigned LANE_W   = (BUS_BYTES < 2) ? 1 : $clog2(BUS_BYTES),
  localparam int unsigned IDX_W    = dbell_pkg::idx_bits(MAX_IDX)
) (
  input  logic [ADDR_W-1:0]      off,
  input  logic [LANE_W-1:0]      lane,
  input  logic [8*BUS_BYTES-1:0] data,
  output logic [IDX_W-1:0]       idx,
  output logic                   stride_bad,
  output logic                   range_bad
);

  generate
    if (STRIDE == 0) begin : g_shared
      // All doorbells share the base address; the value names the doorbell.
      localparam int unsigned VW = 8 * WIDTH_B;
      localparam logic [VW-1:0] VMAX = VW'(MAX_IDX);
      logic [VW-1:0] val;
      always_comb begin
        val        = VW'(data >> {lane, 3'b000});
        stride_bad = off != '0;
        range_bad  = val > VMAX;
        idx        = val[IDX_W-1:0];
      end
    end else begin : g_stride
      localparam int unsigned SHIFT = dbell_pkg::stride_shift(STRIDE);
      localparam logic [ADDR_W-1:0] SMASK = ADDR_W'(STRIDE - 1);
      localparam logic [ADDR_W-1:0] AMAX  = ADDR_W'(MAX_IDX);
      logic [ADDR_W-1:0] raw;
      logic              unused_payload;
      always_comb begin
        raw            = off >> SHIFT;
        stride_bad     = (off & SMASK) != '0;
        range_bad      = raw > AMAX;
        idx            = raw[IDX_W-1:0];
        unused_payload = ^{data, lane};
      end
    end
  endgenerate

endmodule

// File: rtl/dbell_out_reg.sv
module dbell_out_reg #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             fault,
  input  logic [IDX_W-1:0] idx_in,
  output logic             pulse,
  output logic             err,
  output logic [IDX_W-1:0] idx
);

  logic             pulse_nxt;
  logic             err_nxt;
  logic             idx_en;
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    pulse_nxt = fire;
    err_nxt   = fault & ~fire;
    idx_en    = fire;
    idx_nxt   = idx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      err   <= 1'b0;
    end else begin
      pulse <= pulse_nxt;
      err   <= err_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_nxt;
    end
  end

  // R10
  ring_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse && err));

endmodule

// File: rtl/dbell_decoder.sv
module dbell_decoder #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned WIDTH_B   = 4,
  parameter int unsigned BASE_OFF  = 256,
  parameter int unsigned STRIDE    = 8,
  parameter int unsigned MAX_IDX   = 5,
  parameter int unsigned WIN_LEN   = 64,
  localparam int unsigned LANE_W   = (BUS_BYTES < 2) ? 1 : $clog2(BUS_BYTES),
  localparam int unsigned IDX_W    = dbell_pkg::idx_bits(MAX_IDX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [BUS_BYTES-1:0]   wr_be,
  input  logic [8*BUS_BYTES-1:0] wr_data,
  output logic                   ring_pulse,
  output logic [IDX_W-1:0]       ring_idx,
  output logic                   ring_err
);

  import dbell_pkg::*;

  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_IDX);

  logic [ADDR_W-1:0] off;
  logic [LANE_W-1:0] lane;
  logic [IDX_W-1:0]  idx_calc;
  db_diag_t          diag;
  logic              fire;
  logic              fault;

  dbell_window #(
    .ADDR_W   (ADDR_W),
    .BUS_BYTES(BUS_BYTES),
    .WIDTH_B  (WIDTH_B),
    .BASE_OFF (BASE_OFF),
    .WIN_LEN  (WIN_LEN)
  ) u_win (
    .addr     (wr_addr),
    .be       (wr_be),
    .off      (off),
    .lane     (lane),
    .in_win   (diag.in_win),
    .width_bad(diag.width_bad),
    .lanes_bad(diag.lanes_bad)
  );

  dbell_index #(
    .ADDR_W   (ADDR_W),
    .BUS_BYTES(BUS_BYTES),
    .WIDTH_B  (WIDTH_B),
    .STRIDE   (STRIDE),
    .MAX_IDX  (MAX_IDX)
  ) u_idx (
    .off       (off),
    .lane      (lane),
    .data      (wr_data),
    .idx       (idx_calc),
    .stride_bad(diag.stride_bad),
    .range_bad (diag.range_bad)
  );

  always_comb begin
    fault = wr_valid & diag.in_win &
            (diag.width_bad | diag.lanes_bad | diag.stride_bad | diag.range_bad);
    fire  = wr_valid & diag.in_win & ~fault;
  end

  dbell_out_reg #(
    .IDX_W(IDX_W)
  ) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .fault (fault),
    .idx_in(idx_calc),
    .pulse (ring_pulse),
    .err   (ring_err),
    .idx   (ring_idx)
  );

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (!ring_pulse && !ring_err));

  // R7
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !diag.in_win) |=> (!ring_pulse && !ring_err));

  // R4
  misalign_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && diag.in_win && (diag.stride_bad || diag.width_bad))
      |=> (ring_err && !ring_pulse));

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_pulse |-> (ring_idx <= IDX_TOP));

  // R2
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_pulse && !fire) |=> !ring_pulse);

endmodule

// File: tb/sim_dbell_decoder.sv
module sim_dbell_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;

  logic       p0, e0, p1, e1;
  logic [2:0] i0;
  logic [1:0] i1;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;
  bit done = 0;

  typedef struct {
    int     k0;
    int     x0;
    int     k1;
    int     x1;
    string  req;
    longint stamp;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Stride 8, 4-byte doorbells at 0x100.., indices 0..5, window 64 bytes.
  dbell_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data),
    .ring_pulse(p0), .ring_idx(i0), .ring_err(e0)
  );

  // Shared address 0x42, 2-byte value in lanes 2..3, indices 0..3.
  dbell_decoder #(
    .WIDTH_B(2), .BASE_OFF(66), .STRIDE(0), .MAX_IDX(3), .WIN_LEN(2)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data),
    .ring_pulse(p1), .ring_idx(i1), .ring_err(e1)
  );

  // kind: 0 nothing, 1 pulse, 2 error
  task automatic cmp(input string who, input string req, input int k, input int x,
                     input logic p, input logic e, input int idx);
    logic ok;
    ok = (p == (k == 1)) && (e == (k == 2)) && ((k != 1) || (idx == x));
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got pulse=%0b err=%0b idx=%0d, expected kind=%0d idx=%0d",
               req, who, p, e, idx, k, x);
    end
  endtask

  task automatic wr(input logic v, input logic [11:0] a, input logic [3:0] be,
                    input logic [31:0] d, input int k0, input int x0,
                    input int k1, input int x1, input string req);
    exp_t t;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_be = be; wr_data = d;
    t.k0 = k0; t.x0 = x0; t.k1 = k1; t.x1 = x1; t.req = req; t.stamp = cyc;
    sb.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) wr(1'b0, 12'h100, 4'hF, 32'h0, 0, 0, 0, 0, "R8");
  endtask

  // Monitor: results of a write are due after the following rising edge.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0 && sb[0].stamp < cyc) begin
      exp_t t;
      t = sb.pop_front();
      cmp("u0", t.req, t.k0, t.x0, p0, e0, int'(i0));
      cmp("u1", t.req, t.k1, t.x1, p1, e1, int'(i1));
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cmp("u0", "R1", 0, 0, p0, e0, int'(i0)); checks++; if (i0 != 0) begin fails++; $display("FAIL R1 u0 idx got %0d expected 0", i0); end
    cmp("u1", "R1", 0, 0, p1, e1, int'(i1)); checks++; if (i1 != 0) begin fails++; $display("FAIL R1 u1 idx got %0d expected 0", i1); end
    rst_n = 1'b1;
    @(negedge clk);
    cmp("u0", "R1", 0, 0, p0, e0, int'(i0));
    cmp("u1", "R1", 0, 0, p1, e1, int'(i1));

    // R2 single doorbells with idle gaps
    wr(1, 12'h100, 4'hF, 32'h0, 1, 0, 0, 0, "R2");
    idle(1);
    wr(1, 12'h128, 4'hF, 32'h0, 1, 5, 0, 0, "R2");
    idle(2);
    // R3 back-to-back
    wr(1, 12'h108, 4'hF, 32'h0, 1, 1, 0, 0, "R3");
    wr(1, 12'h110, 4'hF, 32'h0, 1, 2, 0, 0, "R3");
    wr(1, 12'h118, 4'hF, 32'h0, 1, 3, 0, 0, "R3");
    wr(1, 12'h104, 4'hF, 32'h0, 2, 0, 0, 0, "R3");
    wr(1, 12'h120, 4'hF, 32'h0, 1, 4, 0, 0, "R3");
    idle(1);
    // R4 stride and width misalignment
    wr(1, 12'h104, 4'hF, 32'h0, 2, 0, 0, 0, "R4");
    wr(1, 12'h102, 4'hF, 32'h0, 2, 0, 0, 0, "R4");
    wr(1, 12'h13C, 4'hF, 32'h0, 2, 0, 0, 0, "R4");
    // R5 index beyond the maximum inside the window
    wr(1, 12'h130, 4'hF, 32'h0, 2, 0, 0, 0, "R5");
    wr(1, 12'h138, 4'hF, 32'h0, 2, 0, 0, 0, "R5");
    // R6 byte lane mismatch
    wr(1, 12'h110, 4'h7, 32'h0, 2, 0, 0, 0, "R6");
    wr(1, 12'h110, 4'h0, 32'h0, 2, 0, 0, 0, "R6");
    // R7 outside both windows
    wr(1, 12'h140, 4'hF, 32'h0, 0, 0, 0, 0, "R7");
    wr(1, 12'h0F8, 4'hF, 32'h0, 0, 0, 0, 0, "R7");
    wr(1, 12'h044, 4'h3, 32'h0, 0, 0, 0, 0, "R7");
    // R8 valid low on legal doorbell addresses
    wr(0, 12'h108, 4'hF, 32'h0, 0, 0, 0, 0, "R8");
    wr(0, 12'h042, 4'hC, 32'h0002_0000, 0, 0, 0, 0, "R8");
    // R9 shared-address mode on u1
    wr(1, 12'h042, 4'hC, 32'h0002_0000, 0, 0, 1, 2, "R9");
    wr(1, 12'h042, 4'hC, 32'h0003_FFFF, 0, 0, 1, 3, "R9");
    wr(1, 12'h042, 4'hC, 32'h0000_1234, 0, 0, 1, 0, "R9");
    wr(1, 12'h043, 4'h8, 32'h0100_0000, 0, 0, 2, 0, "R9");
    wr(1, 12'h042, 4'hC, 32'h0001_0000, 0, 0, 1, 1, "R9");
    // R5 value out of range in shared mode
    wr(1, 12'h042, 4'hC, 32'h0004_0000, 0, 0, 2, 0, "R5");
    wr(1, 12'h042, 4'hC, 32'h0100_0000, 0, 0, 2, 0, "R5");
    // R6 in shared mode
    wr(1, 12'h042, 4'h4, 32'h0001_0000, 0, 0, 2, 0, "R6");
    wr(1, 12'h042, 4'hF, 32'h0001_0000, 0, 0, 2, 0, "R6");
    // R10 alternation of pulse and error
    wr(1, 12'h100, 4'hF, 32'h0, 1, 0, 0, 0, "R10");
    wr(1, 12'h101, 4'h2, 32'h0, 2, 0, 0, 0, "R10");
    wr(1, 12'h128, 4'hF, 32'h0, 1, 5, 0, 0, "R10");
    idle(3);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule